// File: doc/BRIEF.md
# Deferred-commit link configuration registers

This block holds the capability and configuration registers of a serial host-to-peripheral link agent. The command decoder in front of it presents GET and SET accesses. Each access carries a register offset, a 32-bit write word and a read strobe. A SET does not change the agent's behaviour at once. It fills a staging copy of the configuration. That copy becomes the live configuration on the clock edge at which the active-low chip select is first seen high again. Until then, every output and every GET still shows the previous live settings.

The live settings drive the rest of the agent:

- CRC enable and alert signalling mode.
- I/O width, clock frequency code and maximum wait states.
- The peripheral channel's read-request size, payload size and enable.
- The virtual wire channel's operating count and enable.

When a commit turns the peripheral channel's enable from 1 to 0, the block emits a one-cycle reset pulse for that channel. Turning off the virtual wire channel never produces a pulse and leaves its wire count in place. Read-only fields report build-time capabilities and the two channel-ready inputs.

Top module: `linkcfg_regs`

## Requirements
- R1: After the active-low link reset, the live settings are as follows: CRC enable 0, alert mode 0, I/O mode 00, frequency code 000, wait code 0000, read-request size 001, payload size 001, peripheral enable 1, virtual wire count 0 and virtual wire enable 0. The reset pulse, rd_data and rd_err are all 0.
- R2: A SET taken while cs_n is low changes no output and no GET result. The staged values appear on the outputs after the first clock edge at which cs_n is sampled high following a low sample.
- R3: A SET presented while cs_n is high is ignored and is not committed later.
- R4: When several SETs reach one register within one chip-select assertion, only the last staged value commits.
- R5: A GET returns its word on rd_data, with rd_err, one clock after the read strobe, and reflects the live values. Offset 0x04 reads 0x00000001. Offset 0x08 holds the following fields:
  - CRC enable in bit 31.
  - Alert mode in bit 28.
  - I/O mode in bits 27:26.
  - Build-time mode in bits 25:24.
  - Frequency code in bits 22:20.
  - Build-time supported frequency in bits 18:16.
  - Wait code in bits 15:12.
  - Build-time channel mask in bits 7:0.
- R6: Offset 0x10 holds the read-request size in bits 14:12, the payload size in bits 10:8, the build-time maximum payload in bits 6:4, ch0_ready in bit 1 and the enable in bit 0. Offset 0x20 holds the virtual wire count (count minus one) in bits 21:16, the build-time maximum count in bits 13:8, ch1_ready in bit 1 and the enable in bit 0.
- R7: Reserved codes in a SET are ignored and the field keeps its previous value. This covers I/O mode 11, frequency codes above 100, size code 000, a payload code above the supported maximum, and a virtual wire code above the supported maximum. Frequency 100 and a wire code equal to the maximum are accepted.
- R8: Writes to reserved or read-only bits, or to offsets 0x04, 0x30 or 0x40, change nothing. Reserved bits read 0.
- R9: A GET at an unmapped offset returns 0 with rd_err = 1. A GET at 0x30 or 0x40 returns 0 with rd_err = 0.
- R10: A commit that changes the peripheral enable from 1 to 0 raises ch0_rst_pulse for exactly one cycle, in the same cycle that cfg_ch0_en falls. A commit that leaves the enable unchanged or sets it to 1 raises no pulse.
- R11: A commit that clears the virtual wire enable raises no reset pulse and keeps the virtual wire count unchanged.
- R12: A link reset asserted during a chip-select assertion discards the staged values. A later chip-select release commits the defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low link reset, asynchronous |
| cs_n | input | 1 | Active-low chip select; its rising edge commits staged values |
| acc_set | input | 1 | SET access strobe |
| acc_get | input | 1 | GET access strobe |
| acc_off | input | ADDR_W | Register offset of the access |
| acc_wdata | input | 32 | SET write word |
| ch0_ready | input | 1 | Peripheral channel ready, reported in the read-only field |
| ch1_ready | input | 1 | Virtual wire channel ready, reported in the read-only field |
| rd_data | output | 32 | GET result, valid one cycle after acc_get |
| rd_err | output | 1 | Unmapped-offset flag for the last GET |
| cfg_crc_en | output | 1 | Live CRC enable |
| cfg_alert_pin | output | 1 | Live alert mode: 1 dedicated pin, 0 data line 1 |
| cfg_io_mode | output | 2 | Live I/O width: 00 single, 01 dual, 10 quad |
| cfg_freq | output | 3 | Live frequency code |
| cfg_wait_max | output | 4 | Live wait-state code (0 means 16 byte times) |
| cfg_ch0_rd_size | output | 3 | Live peripheral read-request size code |
| cfg_ch0_pay_size | output | 3 | Live peripheral payload size code |
| cfg_ch0_en | output | 1 | Live peripheral channel enable |
| cfg_ch1_vw_cnt | output | 6 | Live virtual wire count minus one |
| cfg_ch1_en | output | 1 | Live virtual wire channel enable |
| ch0_rst_pulse | output | 1 | One-cycle peripheral channel reset |

## Verification
The bench reads registers between a SET and the chip-select release, and between back-to-back SETs. This exposes a design that applies writes at once, because its outputs and GET words would change before the release. A design that keeps the first of several writes would commit the wrong wait code.

The bench also writes every reserved code and each value exactly at the legal limits. A wrong legality check would either corrupt a field or reject frequency 100 and the maximum wire count.

The reset pulse is counted across three kinds of commit: a disable of the peripheral channel, a repeat of the same setting, and a disable of the virtual wire channel. This catches a pulse on the wrong channel, a pulse that is level-driven, and a pulse two cycles wide.

Finally, a link reset in the middle of a chip-select assertion catches staged values that survive the reset.

// File: rtl/linkcfg_pkg.sv
package linkcfg_pkg;

    typedef struct packed {
        logic       crc_en;
        logic       alert_pin;
        logic [1:0] io_mode;
        logic [2:0] freq;
        logic [3:0] wait_max;
        logic [2:0] rd_size;
        logic [2:0] pay_size;
        logic       p_en;
        logic [5:0] vw_cnt;
        logic       vw_en;
    } lcfg_t;

    typedef struct packed {
        lcfg_t       stg;
        lcfg_t       live;
        logic        pulse;
        logic [31:0] rdat;
        logic        rerr;
    } lstate_t;

    localparam lcfg_t LCFG_RESET = '{
        crc_en: 1'b0, alert_pin: 1'b0, io_mode: 2'b00, freq: 3'b000,
        wait_max: 4'h0, rd_size: 3'b001, pay_size: 3'b001, p_en: 1'b1,
        vw_cnt: 6'd0, vw_en: 1'b0
    };

    localparam lstate_t LSTATE_RESET = '{
        stg: LCFG_RESET, live: LCFG_RESET, pulse: 1'b0, rdat: 32'h0, rerr: 1'b0
    };

    localparam int unsigned OFS_ID  = 32'h04;
    localparam int unsigned OFS_GEN = 32'h08;
    localparam int unsigned OFS_CH0 = 32'h10;
    localparam int unsigned OFS_CH1 = 32'h20;
    localparam int unsigned OFS_CH2 = 32'h30;
    localparam int unsigned OFS_CH3 = 32'h40;

    localparam logic [1:0] IO_RSVD  = 2'b11;
    localparam logic [2:0] FREQ_TOP = 3'b100;

endpackage

// File: rtl/linkcfg_cs_edge.sv
module linkcfg_cs_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    output logic cs_active,
    output logic commit
);
    logic cs_n_d, cs_n_q;

    always_comb begin
        cs_n_d    = cs_n;
        cs_active = ~cs_n;
        commit    = cs_n & ~cs_n_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cs_n_q <= 1'b1;
        else        cs_n_q <= cs_n_d;
    end

    // R2: a commit needs a low sample before it, so two in a row cannot occur
    a_r2_single_commit: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit);
endmodule

// File: rtl/linkcfg_stage_upd.sv
module linkcfg_stage_upd
    import linkcfg_pkg::*;
#(
    parameter int unsigned ADDR_W  = 8,
    parameter logic [2:0]  MAX_PAY = 3'b001,
    parameter logic [5:0]  MAX_VW  = 6'd7
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] off,
    input  logic [31:0]       wdata,
    input  lcfg_t             cur,
    output lcfg_t             nxt
);
    localparam logic [ADDR_W-1:0] A_GEN = ADDR_W'(OFS_GEN);
    localparam logic [ADDR_W-1:0] A_CH0 = ADDR_W'(OFS_CH0);
    localparam logic [ADDR_W-1:0] A_CH1 = ADDR_W'(OFS_CH1);

    logic unused_bits;
    assign unused_bits = ^{wdata[30:29], wdata[25:23], wdata[11], wdata[7:1]};

    always_comb begin
        nxt = cur;
        if (wr_en) begin
            case (off)
                A_GEN: begin
                    nxt.crc_en    = wdata[31];
                    nxt.alert_pin = wdata[28];
                    nxt.wait_max  = wdata[15:12];
                    if (wdata[27:26] != IO_RSVD)  nxt.io_mode = wdata[27:26];
                    if (wdata[22:20] <= FREQ_TOP) nxt.freq    = wdata[22:20];
                end
                A_CH0: begin
                    nxt.p_en = wdata[0];
                    if (wdata[14:12] != 3'b000) nxt.rd_size = wdata[14:12];
                    if (wdata[10:8] != 3'b000 && wdata[10:8] <= MAX_PAY)
                        nxt.pay_size = wdata[10:8];
                end
                A_CH1: begin
                    nxt.vw_en = wdata[0];
                    if (wdata[21:16] <= MAX_VW) nxt.vw_cnt = wdata[21:16];
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/linkcfg_regs.sv
module linkcfg_regs
    import linkcfg_pkg::*;
#(
    parameter int unsigned ADDR_W   = 8,
    parameter logic [7:0]  VERSION  = 8'h01,
    parameter logic [1:0]  OP_MODE  = 2'b01,
    parameter logic [2:0]  FREQ_SUP = 3'b011,
    parameter logic [7:0]  CH_SUP   = 8'h03,
    parameter logic [2:0]  MAX_PAY  = 3'b001,
    parameter logic [5:0]  MAX_VW   = 6'd7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              acc_set,
    input  logic              acc_get,
    input  logic [ADDR_W-1:0] acc_off,
    input  logic [31:0]       acc_wdata,
    input  logic              ch0_ready,
    input  logic              ch1_ready,
    output logic [31:0]       rd_data,
    output logic              rd_err,
    output logic              cfg_crc_en,
    output logic              cfg_alert_pin,
    output logic [1:0]        cfg_io_mode,
    output logic [2:0]        cfg_freq,
    output logic [3:0]        cfg_wait_max,
    output logic [2:0]        cfg_ch0_rd_size,
    output logic [2:0]        cfg_ch0_pay_size,
    output logic              cfg_ch0_en,
    output logic [5:0]        cfg_ch1_vw_cnt,
    output logic              cfg_ch1_en,
    output logic              ch0_rst_pulse
);
    localparam logic [ADDR_W-1:0] A_ID  = ADDR_W'(OFS_ID);
    localparam logic [ADDR_W-1:0] A_GEN = ADDR_W'(OFS_GEN);
    localparam logic [ADDR_W-1:0] A_CH0 = ADDR_W'(OFS_CH0);
    localparam logic [ADDR_W-1:0] A_CH1 = ADDR_W'(OFS_CH1);
    localparam logic [ADDR_W-1:0] A_CH2 = ADDR_W'(OFS_CH2);
    localparam logic [ADDR_W-1:0] A_CH3 = ADDR_W'(OFS_CH3);

    lstate_t     st_d, st_q;
    lcfg_t       stg_next;
    logic        cs_active, commit;
    logic [31:0] rd_word;
    logic        rd_miss;

    linkcfg_cs_edge u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .cs_active (cs_active),
        .commit    (commit)
    );

    linkcfg_stage_upd #(
        .ADDR_W  (ADDR_W),
        .MAX_PAY (MAX_PAY),
        .MAX_VW  (MAX_VW)
    ) u_stage (
        .wr_en (acc_set & cs_active),
        .off   (acc_off),
        .wdata (acc_wdata),
        .cur   (st_q.stg),
        .nxt   (stg_next)
    );

    always_comb begin
        rd_word = 32'h0;
        rd_miss = 1'b0;
        case (acc_off)
            A_ID:  rd_word = {24'h0, VERSION};
            A_GEN: rd_word = {st_q.live.crc_en, 2'b00, st_q.live.alert_pin,
                              st_q.live.io_mode, OP_MODE, 1'b0, st_q.live.freq,
                              1'b0, FREQ_SUP, st_q.live.wait_max, 4'h0, CH_SUP};
            A_CH0: rd_word = {17'h0, st_q.live.rd_size, 1'b0, st_q.live.pay_size,
                              1'b0, MAX_PAY, 2'b00, ch0_ready, st_q.live.p_en};
            A_CH1: rd_word = {10'h0, st_q.live.vw_cnt, 2'b00, MAX_VW,
                              6'h0, ch1_ready, st_q.live.vw_en};
            A_CH2, A_CH3: rd_word = 32'h0;
            default: rd_miss = 1'b1;
        endcase
    end

    always_comb begin
        st_d       = st_q;
        st_d.stg   = stg_next;
        st_d.pulse = commit & st_q.live.p_en & ~st_q.stg.p_en;
        if (commit) st_d.live = st_q.stg;
        if (acc_get) begin
            st_d.rdat = rd_word;
            st_d.rerr = rd_miss;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= LSTATE_RESET;
        else        st_q <= st_d;
    end

    assign rd_data          = st_q.rdat;
    assign rd_err           = st_q.rerr;
    assign cfg_crc_en       = st_q.live.crc_en;
    assign cfg_alert_pin    = st_q.live.alert_pin;
    assign cfg_io_mode      = st_q.live.io_mode;
    assign cfg_freq         = st_q.live.freq;
    assign cfg_wait_max     = st_q.live.wait_max;
    assign cfg_ch0_rd_size  = st_q.live.rd_size;
    assign cfg_ch0_pay_size = st_q.live.pay_size;
    assign cfg_ch0_en       = st_q.live.p_en;
    assign cfg_ch1_vw_cnt   = st_q.live.vw_cnt;
    assign cfg_ch1_en       = st_q.live.vw_en;
    assign ch0_rst_pulse    = st_q.pulse;

    a_r2_live_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(st_q.live));

    a_r3_stage_hold: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> $stable(st_q.stg));

    a_r7_codes_legal: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_io_mode != IO_RSVD && cfg_freq <= FREQ_TOP && cfg_ch1_vw_cnt <= MAX_VW);

    a_r7_sizes_legal: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_ch0_rd_size != 3'b000 && cfg_ch0_pay_size != 3'b000 &&
        cfg_ch0_pay_size <= MAX_PAY);

    a_r9_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_err |-> rd_data == 32'h0);

    a_r10_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
        ch0_rst_pulse |=> !ch0_rst_pulse);

    a_r10_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
        ch0_rst_pulse |-> (!cfg_ch0_en && $past(cfg_ch0_en)));
endmodule

// File: tb/sim_linkcfg_regs.sv
`timescale 1ns/1ps
module sim_linkcfg_regs;
    localparam logic [1:0] P_OP   = 2'b01;
    localparam logic [2:0] P_FREQ = 3'b011;
    localparam logic [7:0] P_CH   = 8'h03;
    localparam logic [2:0] P_PAY  = 3'b001;
    localparam logic [5:0] P_VW   = 6'd7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic acc_set = 1'b0, acc_get = 1'b0;
    logic [7:0]  acc_off = 8'h0;
    logic [31:0] acc_wdata = 32'h0;
    logic ch0_ready = 1'b0, ch1_ready = 1'b0;
    logic [31:0] rd_data;
    logic rd_err, cfg_crc_en, cfg_alert_pin, cfg_ch0_en, cfg_ch1_en, ch0_rst_pulse;
    logic [1:0] cfg_io_mode;
    logic [2:0] cfg_freq, cfg_ch0_rd_size, cfg_ch0_pay_size;
    logic [3:0] cfg_wait_max;
    logic [5:0] cfg_ch1_vw_cnt;

    always #2.5 clk = ~clk;

    linkcfg_regs #(.ADDR_W(8), .VERSION(8'h01), .OP_MODE(P_OP), .FREQ_SUP(P_FREQ),
                   .CH_SUP(P_CH), .MAX_PAY(P_PAY), .MAX_VW(P_VW)) u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .acc_set(acc_set), .acc_get(acc_get),
        .acc_off(acc_off), .acc_wdata(acc_wdata), .ch0_ready(ch0_ready),
        .ch1_ready(ch1_ready), .rd_data(rd_data), .rd_err(rd_err),
        .cfg_crc_en(cfg_crc_en), .cfg_alert_pin(cfg_alert_pin), .cfg_io_mode(cfg_io_mode),
        .cfg_freq(cfg_freq), .cfg_wait_max(cfg_wait_max), .cfg_ch0_rd_size(cfg_ch0_rd_size),
        .cfg_ch0_pay_size(cfg_ch0_pay_size), .cfg_ch0_en(cfg_ch0_en),
        .cfg_ch1_vw_cnt(cfg_ch1_vw_cnt), .cfg_ch1_en(cfg_ch1_en),
        .ch0_rst_pulse(ch0_rst_pulse));

    int n_chk = 0, n_bad = 0, pulse_cnt = 0;
    bit run_cmp = 0, done = 0;
    string phase = "R1";

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // reference model: RW bits kept at their register positions
    logic [31:0] m_gen, m_ch0, m_ch1, s_gen, s_ch0, s_ch1, m_rd;
    logic m_err, m_pulse, m_csp;
    bit m_commit;

    function automatic logic [31:0] upd_gen(input logic [31:0] o, input logic [31:0] w);
        logic [31:0] r = o;
        r[31] = w[31];
        r[28] = w[28];
        r[15:12] = w[15:12];
        if (w[27:26] != 2'b11) r[27:26] = w[27:26];
        if (int'(w[22:20]) <= 4) r[22:20] = w[22:20];
        return r;
    endfunction

    function automatic logic [31:0] upd_ch0(input logic [31:0] o, input logic [31:0] w);
        logic [31:0] r = o;
        r[0] = w[0];
        if (w[14:12] != 0) r[14:12] = w[14:12];
        if (w[10:8] != 0 && w[10:8] <= P_PAY) r[10:8] = w[10:8];
        return r;
    endfunction

    function automatic logic [31:0] upd_ch1(input logic [31:0] o, input logic [31:0] w);
        logic [31:0] r = o;
        r[0] = w[0];
        if (w[21:16] <= P_VW) r[21:16] = w[21:16];
        return r;
    endfunction

    function automatic logic [31:0] rd_model(input logic [7:0] a);
        case (a)
            8'h04: return 32'h1;
            8'h08: return m_gen | (32'(P_OP) << 24) | (32'(P_FREQ) << 16) | 32'(P_CH);
            8'h10: return m_ch0 | (32'(P_PAY) << 4) | (32'(ch0_ready) << 1);
            8'h20: return m_ch1 | (32'(P_VW) << 8) | (32'(ch1_ready) << 1);
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_gen <= 0; m_ch0 <= 32'h1101; m_ch1 <= 0;
            s_gen <= 0; s_ch0 <= 32'h1101; s_ch1 <= 0;
            m_rd <= 0; m_err <= 0; m_pulse <= 0; m_csp <= 1;
        end else begin
            m_commit = cs_n && !m_csp;
            if (acc_get) begin
                m_rd  <= rd_model(acc_off);
                m_err <= !(acc_off inside {8'h04, 8'h08, 8'h10, 8'h20, 8'h30, 8'h40});
            end
            m_pulse <= m_commit && m_ch0[0] && !s_ch0[0];
            if (m_commit) begin
                m_gen <= s_gen; m_ch0 <= s_ch0; m_ch1 <= s_ch1;
            end
            if (!cs_n && acc_set) begin
                if (acc_off == 8'h08) s_gen <= upd_gen(s_gen, acc_wdata);
                if (acc_off == 8'h10) s_ch0 <= upd_ch0(s_ch0, acc_wdata);
                if (acc_off == 8'h20) s_ch1 <= upd_ch1(s_ch1, acc_wdata);
            end
            m_csp <= cs_n;
        end
    end

    always @(negedge clk) begin
        if (ch0_rst_pulse) pulse_cnt++;
        if (run_cmp && rst_n) begin
            logic [58:0] a, e;
            a = {cfg_crc_en, cfg_alert_pin, cfg_io_mode, cfg_freq, cfg_wait_max,
                 cfg_ch0_rd_size, cfg_ch0_pay_size, cfg_ch0_en, cfg_ch1_vw_cnt,
                 cfg_ch1_en, ch0_rst_pulse, rd_err, rd_data};
            e = {m_gen[31], m_gen[28], m_gen[27:26], m_gen[22:20], m_gen[15:12],
                 m_ch0[14:12], m_ch0[10:8], m_ch0[0], m_ch1[21:16], m_ch1[0],
                 m_pulse, m_err, m_rd};
            chk(a == e, {phase, " per-cycle model"}, 64'(a), 64'(e));
        end
    end

    task automatic set_reg(input logic [7:0] a, input logic [31:0] w);
        @(negedge clk);
        acc_set = 1; acc_off = a; acc_wdata = w;
        @(negedge clk);
        acc_set = 0;
    endtask

    task automatic get_reg(input logic [7:0] a, output logic [31:0] d, output logic e);
        @(negedge clk);
        acc_get = 1; acc_off = a;
        @(negedge clk);
        acc_get = 0;
        d = rd_data; e = rd_err;
    endtask

    task automatic cs_low();
        @(negedge clk);
        cs_n = 0;
    endtask

    task automatic cs_high();
        @(negedge clk);
        cs_n = 1;
        @(negedge clk);
    endtask

    task automatic chk_defaults(input string tag);
        chk({cfg_crc_en, cfg_alert_pin, cfg_io_mode, cfg_freq, cfg_wait_max} == 0,
            tag, 64'({cfg_crc_en, cfg_alert_pin, cfg_io_mode, cfg_freq, cfg_wait_max}), 0);
        chk({cfg_ch0_rd_size, cfg_ch0_pay_size, cfg_ch0_en} == 7'b0010011, tag,
            64'({cfg_ch0_rd_size, cfg_ch0_pay_size, cfg_ch0_en}), 64'b0010011);
        chk({cfg_ch1_vw_cnt, cfg_ch1_en, ch0_rst_pulse} == 0, tag,
            64'({cfg_ch1_vw_cnt, cfg_ch1_en, ch0_rst_pulse}), 0);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic e;
        repeat (3) @(negedge clk);
        rst_n = 1;
        run_cmp = 1;
        @(negedge clk);
        phase = "R1";
        chk_defaults("R1 reset");
        chk(rd_data == 0 && rd_err == 0, "R1 read regs", 64'({rd_err, rd_data}), 0);

        phase = "R5";
        get_reg(8'h04, d, e); chk(d == 32'h1 && !e, "R5 id", 64'(d), 64'h1);
        get_reg(8'h08, d, e); chk(d == 32'h01030003, "R5 general", 64'(d), 64'h01030003);
        phase = "R6";
        ch0_ready = 1;
        get_reg(8'h10, d, e); chk(d == 32'h1113, "R6 ch0", 64'(d), 64'h1113);
        get_reg(8'h20, d, e); chk(d == 32'h700, "R6 ch1", 64'(d), 64'h700);
        ch1_ready = 1;
        get_reg(8'h20, d, e); chk(d == 32'h702, "R6 ch1 ready", 64'(d), 64'h702);
        ch0_ready = 0; ch1_ready = 0;

        phase = "R2";
        cs_low();
        set_reg(8'h08, 32'h98305000);
        repeat (3) @(negedge clk);
        chk({cfg_crc_en, cfg_io_mode, cfg_freq, cfg_wait_max} == 0, "R2 held before release",
            64'({cfg_crc_en, cfg_io_mode, cfg_freq, cfg_wait_max}), 0);
        get_reg(8'h08, d, e); chk(d == 32'h01030003, "R2 read held", 64'(d), 64'h01030003);
        cs_high();
        chk({cfg_crc_en, cfg_alert_pin, cfg_io_mode, cfg_freq, cfg_wait_max} == 12'b1110_0110_101,
            "R2 committed", 64'({cfg_crc_en, cfg_alert_pin, cfg_io_mode, cfg_freq, cfg_wait_max}),
            64'b1110_0110_101);
        get_reg(8'h08, d, e); chk(d == 32'h99335003, "R5 general live", 64'(d), 64'h99335003);

        phase = "R3";
        set_reg(8'h08, 32'h0);
        cs_low(); cs_high();
        chk(cfg_crc_en == 1 && cfg_wait_max == 5, "R3 set with cs high ignored",
            64'({cfg_crc_en, cfg_wait_max}), 64'h15);

        phase = "R4";
        cs_low();
        set_reg(8'h08, 32'h00002000);
        set_reg(8'h08, 32'h80007000);
        cs_high();
        chk({cfg_crc_en, cfg_alert_pin, cfg_io_mode, cfg_wait_max} == 8'b1000_0111, "R4 last wins",
            64'({cfg_crc_en, cfg_alert_pin, cfg_io_mode, cfg_wait_max}), 64'b1000_0111);

        phase = "R7";
        cs_low();
        set_reg(8'h08, 32'h0C509000);
        set_reg(8'h10, 32'h00000201);
        set_reg(8'h20, 32'h00080001);
        cs_high();
        chk(cfg_io_mode == 0 && cfg_freq == 0 && cfg_wait_max == 9, "R7 io/freq reserved",
            64'({cfg_io_mode, cfg_freq, cfg_wait_max}), 64'h9);
        chk(cfg_ch0_rd_size == 1 && cfg_ch0_pay_size == 1 && cfg_ch1_vw_cnt == 0 && cfg_ch1_en,
            "R7 sizes/count reserved",
            64'({cfg_ch0_rd_size, cfg_ch0_pay_size, cfg_ch1_vw_cnt, cfg_ch1_en}), 64'h481);
        cs_low();
        set_reg(8'h08, 32'h00400000);
        set_reg(8'h20, 32'h00070001);
        set_reg(8'h10, 32'h00003101);
        cs_high();
        chk(cfg_freq == 4 && cfg_ch1_vw_cnt == 7 && cfg_ch0_rd_size == 3, "R7 limits accepted",
            64'({cfg_freq, cfg_ch1_vw_cnt, cfg_ch0_rd_size}), 64'({3'd4, 6'd7, 3'd3}));

        phase = "R8";
        cs_low();
        set_reg(8'h04, 32'hFFFFFFFF);
        set_reg(8'h30, 32'hFFFFFFFF);
        set_reg(8'h40, 32'hFFFFFFFF);
        set_reg(8'h08, 32'h638F0FFF);
        set_reg(8'h10, 32'hFFFF88FF);
        cs_high();
        get_reg(8'h04, d, e); chk(d == 32'h1, "R8 id unchanged", 64'(d), 64'h1);
        get_reg(8'h08, d, e); chk(d == 32'h01030003, "R8 general reserved", 64'(d), 64'h01030003);
        get_reg(8'h10, d, e); chk(d == 32'h3111, "R8 ch0 reserved", 64'(d), 64'h3111);

        phase = "R9";
        get_reg(8'h0C, d, e); chk(d == 0 && e, "R9 unmapped", 64'({e, d}), 64'h1_0000_0000);
        get_reg(8'h30, d, e); chk(d == 0 && !e, "R9 ch2", 64'({e, d}), 0);
        get_reg(8'h40, d, e); chk(d == 0 && !e, "R9 ch3", 64'({e, d}), 0);
        get_reg(8'h44, d, e); chk(d == 0 && e, "R9 beyond", 64'({e, d}), 64'h1_0000_0000);

        phase = "R10";
        pulse_cnt = 0;
        cs_low(); set_reg(8'h10, 32'h00001100); cs_high();
        repeat (3) @(negedge clk);
        chk(pulse_cnt == 1 && !cfg_ch0_en, "R10 disable pulse once",
            64'(pulse_cnt), 64'h1);
        cs_low(); cs_high();
        repeat (2) @(negedge clk);
        chk(pulse_cnt == 1, "R10 repeat commit no pulse", 64'(pulse_cnt), 64'h1);
        cs_low(); set_reg(8'h10, 32'h00001101); cs_high();
        repeat (2) @(negedge clk);
        chk(pulse_cnt == 1 && cfg_ch0_en, "R10 enable no pulse", 64'(pulse_cnt), 64'h1);

        phase = "R11";
        pulse_cnt = 0;
        cs_low(); set_reg(8'h20, 32'h00070000); cs_high();
        repeat (2) @(negedge clk);
        chk(pulse_cnt == 0 && !cfg_ch1_en && cfg_ch1_vw_cnt == 7, "R11 vw disable",
            64'({pulse_cnt[7:0], cfg_ch1_en, cfg_ch1_vw_cnt}), 64'h7);

        phase = "R12";
        cs_low();
        set_reg(8'h08, 32'h80000000);
        set_reg(8'h10, 32'h00003100);
        @(negedge clk); rst_n = 0;
        repeat (2) @(negedge clk); rst_n = 1;
        @(negedge clk);
        chk_defaults("R12 during reset");
        cs_high();
        chk_defaults("R12 staged discarded");

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule